// File: doc/BRIEF.md
# Two-Phase Incremental Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a signed movement count held in an unsigned register. Each phase pin can be inverted. Each then passes through a two-stage synchronizer and a digital glitch filter, which accepts a new level only after a programmable number of agreeing samples. The decoder then compares the filtered phase that just moved with the other phase. From that comparison it steps the counter up or down and records the direction of the last step.

The counter covers the closed range from zero to a reload limit. Stepping up from the limit returns to zero, stepping down from zero returns to the limit, and either wrap raises a single-cycle pulse. A two-bit source selector sets which phases produce steps: phase A only, phase B only, or both. The selector value zero halts counting. The reload limit is taken from its input port only while counting is halted. A move of both filtered phases in the same cycle cannot be decoded, so it leaves the state untouched and raises a one-cycle error pulse.

Top module: `qdec_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `count` = 0, `dir_down` = 0, and `wrap` and `err` low.
- R2: In source mode 3 (both phases), the phase sequence (A,B) 00→10→11→01→00 advances `count` by one per transition and drives `dir_down` to 0.
- R3: In source mode 3, the reverse sequence 00→01→11→10→00 lowers `count` by one per transition and drives `dir_down` to 1. A transition of phase A steps down when A equals B after the edge. A transition of phase B steps down when B differs from A after the edge.
- R4: In source mode 1, only phase A transitions step the counter. Phase B transitions leave `count` and `dir_down` unchanged.
- R5: In source mode 2, only phase B transitions step the counter. Phase A transitions leave `count` and `dir_down` unchanged.
- R6: In source mode 0, no transition changes `count` or `dir_down`.
- R7: Stepping up while `count` is at or above the reload limit loads 0 and pulses `wrap` for one cycle.
- R8: Stepping down while `count` is 0 loads the reload limit and pulses `wrap` for one cycle.
- R9: If both filtered phases change in the same cycle while the source mode is nonzero, `count` and `dir_down` keep their values, `wrap` stays low and `err` pulses for one cycle.
- R10: The reload limit follows `reload_val` only in cycles where the source mode is 0. Changes made while counting have no effect on the wrap point.
- R11: Setting `inv_a` (or `inv_b`) inverts that phase before decoding, which reverses the step direction of the same pin motion.
- R12: With `flt_len` = N > 0, a filtered level changes only after N consecutive differing samples taken on cycles with `samp_en` high. A pulse shorter than N samples is discarded. With N = 0 the synchronized level passes through unfiltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| samp_en | input | 1 | Filter sample strobe |
| phase_a | input | 1 | Encoder phase A pin |
| phase_b | input | 1 | Encoder phase B pin |
| inv_a | input | 1 | Invert phase A |
| inv_b | input | 1 | Invert phase B |
| flt_len | input | FLT_W (4) | Agreeing samples needed, 0 = bypass |
| src_mode | input | 2 | 0 halt, 1 phase A, 2 phase B, 3 both |
| reload_val | input | CNT_W (16) | Upper limit of the count range |
| count | output | CNT_W (16) | Position count |
| dir_down | output | 1 | Direction of last step, 1 = down |
| wrap | output | 1 | One-cycle pulse on wrap at either end |
| err | output | 1 | One-cycle pulse on an undecodable double transition |

## Verification
A valid step and a range wrap happen in the same cycle whenever a transition meets a boundary. The bench drives the phases across the limit in both directions and checks that the wrap pulse comes with the expected value of 0 or of the limit. The error pulse and the step logic compete for a cycle in which both filtered phases move at once. This is provoked by changing both pins on one clock edge. The result is judged by an unchanged count and direction, a counted error pulse and no wrap.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_A    = 2'd1,
        SRC_B    = 2'd2,
        SRC_BOTH = 2'd3
    } src_mode_e;

    // decoded decision for one cycle
    typedef struct packed {
        logic step;   // move the counter
        logic down;   // direction of that move
        logic bad;    // both phases moved together
    } step_t;

endpackage

// File: rtl/qdec_chan.sv
// One phase path: polarity, two-flop synchronizer, sample-counting filter.
module qdec_chan #(
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic             pin,
    input  logic             invert,
    input  logic [FLT_W-1:0] flt_len,
    output logic             level
);
    localparam logic [FLT_W-1:0] RUN_ONE = FLT_W'(1);

    typedef struct packed {
        logic [1:0]       sync;
        logic             lvl;
        logic [FLT_W-1:0] run;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     smp;
    logic [FLT_W-1:0] run_inc;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], pin ^ invert};
        smp       = st_q.sync[1];
        run_inc   = st_q.run + RUN_ONE;
        if (flt_len == '0) begin
            st_d.lvl = smp;
            st_d.run = '0;
        end else if (samp_en) begin
            if (smp == st_q.lvl) begin
                st_d.run = '0;
            end else if (run_inc >= flt_len) begin
                st_d.lvl = smp;
                st_d.run = '0;
            end else begin
                st_d.run = run_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;

endmodule

// File: rtl/qdec_decode.sv
// Phase comparison: turns the current and previous filtered levels into a step.
module qdec_decode
    import qdec_pkg::*;
(
    input  logic      a_now,
    input  logic      b_now,
    input  logic      a_prev,
    input  logic      b_prev,
    input  logic [1:0] mode,
    output step_t     dec
);
    logic edge_a, edge_b;

    always_comb begin
        edge_a = a_now ^ a_prev;
        edge_b = b_now ^ b_prev;
        dec    = '0;
        if (mode != SRC_OFF) begin
            if (edge_a && edge_b) begin
                dec.bad = 1'b1;
            end else if (edge_a && mode[0]) begin
                dec.step = 1'b1;
                dec.down = (a_now == b_now);
            end else if (edge_b && mode[1]) begin
                dec.step = 1'b1;
                dec.down = (a_now != b_now);
            end
        end
    end

endmodule

// File: rtl/qdec_wrapctr.sv
// Next-value arithmetic for a counter bounded by zero and a limit.
module qdec_wrapctr #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] limit,
    input  logic             down,
    output logic [CNT_W-1:0] nxt,
    output logic             wrapped
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_comb begin
        wrapped = 1'b0;
        if (down) begin
            if (cur == '0) begin
                nxt     = limit;
                wrapped = 1'b1;
            end else begin
                nxt = cur - CNT_ONE;
            end
        end else begin
            if (cur >= limit) begin
                nxt     = '0;
                wrapped = 1'b1;
            end else begin
                nxt = cur + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             inv_a,
    input  logic             inv_b,
    input  logic [FLT_W-1:0] flt_len,
    input  logic [1:0]       src_mode,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             wrap,
    output logic             err
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             down;
        logic             wrap;
        logic             err;
        logic             a_prev;
        logic             b_prev;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    logic             lvl_a, lvl_b;
    step_t            dec;
    logic [CNT_W-1:0] cnt_nxt;
    logic             cnt_wrapped;
    logic [CNT_W-1:0] reload_q;

    qdec_chan #(.FLT_W(FLT_W)) u_chan_a (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en),
        .pin(phase_a), .invert(inv_a), .flt_len(flt_len), .level(lvl_a)
    );

    qdec_chan #(.FLT_W(FLT_W)) u_chan_b (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en),
        .pin(phase_b), .invert(inv_b), .flt_len(flt_len), .level(lvl_b)
    );

    qdec_decode u_dec (
        .a_now(lvl_a), .b_now(lvl_b),
        .a_prev(st_q.a_prev), .b_prev(st_q.b_prev),
        .mode(src_mode), .dec(dec)
    );

    qdec_wrapctr #(.CNT_W(CNT_W)) u_ctr (
        .cur(st_q.cnt), .limit(st_q.reload), .down(dec.down),
        .nxt(cnt_nxt), .wrapped(cnt_wrapped)
    );

    always_comb begin
        st_d        = st_q;
        st_d.a_prev = lvl_a;
        st_d.b_prev = lvl_b;
        st_d.wrap   = 1'b0;
        st_d.err    = dec.bad;
        if (src_mode == SRC_OFF) begin
            st_d.reload = reload_val;
        end
        if (dec.step) begin
            st_d.cnt  = cnt_nxt;
            st_d.down = dec.down;
            st_d.wrap = cnt_wrapped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.reload <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_q = st_q.reload;
    assign count    = st_q.cnt;
    assign dir_down = st_q.down;
    assign wrap     = st_q.wrap;
    assign err      = st_q.err;

endmodule

// File: rtl/qdec_counter_chk.sv
module qdec_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       src_mode,
    input logic [CNT_W-1:0] count,
    input logic             dir_down,
    input logic             wrap,
    input logic             err,
    input logic [CNT_W-1:0] reload_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !dir_down && !wrap && !err));

    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !wrap && count != $past(count))
        |-> (count == $past(count) + ONE || count == $past(count) - ONE));

    a_r6_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_mode) == 2'd0) |-> ($stable(count) && $stable(dir_down)));

    a_r7_up_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !dir_down) |-> count == '0);

    a_r8_down_wrap_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && dir_down) |-> count == reload_q);

    a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(count) && $stable(dir_down) && !wrap));

    a_r10_limit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_mode) != 2'd0) |-> $stable(reload_q));

endmodule

bind qdec_counter qdec_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_mode(src_mode), .count(count),
    .dir_down(dir_down), .wrap(wrap), .err(err), .reload_q(reload_q)
);

// File: tb/qdec_counter_test.sv
module qdec_counter_test;
    localparam int CNT_W = 16;
    localparam int FLT_W = 4;

    typedef struct packed {
        logic       a;
        logic       b;
        logic [7:0] cnt;
        logic       dn;
    } vec_t;

    // mode 3, limit 5, starting from (0,0) and count 0
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'd1, 1'b0},
        '{1'b1, 1'b1, 8'd2, 1'b0},
        '{1'b0, 1'b1, 8'd3, 1'b0},
        '{1'b0, 1'b0, 8'd4, 1'b0},
        '{1'b1, 1'b0, 8'd5, 1'b0},
        '{1'b1, 1'b1, 8'd0, 1'b0},
        '{1'b0, 1'b1, 8'd1, 1'b0},
        '{1'b1, 1'b1, 8'd0, 1'b1},
        '{1'b1, 1'b0, 8'd5, 1'b1},
        '{1'b0, 1'b0, 8'd4, 1'b1},
        '{1'b0, 1'b1, 8'd3, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             samp_en = 1'b0;
    logic             phase_a = 1'b0;
    logic             phase_b = 1'b0;
    logic             inv_a = 1'b0;
    logic             inv_b = 1'b0;
    logic [FLT_W-1:0] flt_len = '0;
    logic [1:0]       src_mode = 2'd0;
    logic [CNT_W-1:0] reload_val = 16'd5;
    logic [CNT_W-1:0] count;
    logic             dir_down;
    logic             wrap;
    logic             err;

    int tests = 0;
    int fails = 0;
    int wraps = 0;
    int errs  = 0;
    bit done  = 1'b0;

    qdec_counter #(.CNT_W(CNT_W), .FLT_W(FLT_W)) uut (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en),
        .phase_a(phase_a), .phase_b(phase_b), .inv_a(inv_a), .inv_b(inv_b),
        .flt_len(flt_len), .src_mode(src_mode), .reload_val(reload_val),
        .count(count), .dir_down(dir_down), .wrap(wrap), .err(err)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(negedge clk);
        samp_en = ~samp_en;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (wrap) wraps++;
            if (err)  errs++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic move(input logic a, input logic b, input int settle);
        @(negedge clk);
        phase_a = a;
        phase_b = b;
        repeat (settle) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        src_mode = m;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 count in reset", int'(count), 0);
        check("R1 dir in reset", int'(dir_down), 0);
        check("R1 wrap/err in reset", int'(wrap) + int'(err), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        set_mode(2'd3);

        for (int i = 0; i < NV; i++) begin
            move(VECS[i].a, VECS[i].b, 8);
            check(VECS[i].dn ? "R3 count step" : "R2 count step", int'(count), int'(VECS[i].cnt));
            check(VECS[i].dn ? "R3 direction" : "R2 direction", int'(dir_down), int'(VECS[i].dn));
        end
        check("R7 R8 wraps in sequence", wraps, 2);

        // R10: limit change while counting is ignored; wrap still at 5
        @(negedge clk); reload_val = 16'd9;
        move(1'b0, 1'b0, 8);
        move(1'b1, 1'b0, 8);
        check("R10 before limit", int'(count), 5);
        move(1'b1, 1'b1, 8);
        check("R10 old limit wraps", int'(count), 0);
        check("R7 up wrap pulse", wraps, 3);

        // R9: both phases together
        move(1'b0, 1'b0, 8);
        check("R9 count held", int'(count), 0);
        check("R9 dir held", int'(dir_down), 0);
        check("R9 err pulse", errs, 1);
        check("R9 no wrap", wraps, 3);

        // R6: halted; limit 9 is taken here
        set_mode(2'd0);
        move(1'b1, 1'b0, 8);
        move(1'b0, 1'b0, 8);
        check("R6 halted count", int'(count), 0);
        check("R6 halted dir", int'(dir_down), 0);

        // R4: phase A only
        set_mode(2'd1);
        move(1'b0, 1'b1, 8);
        check("R4 B ignored", int'(count), 0);
        move(1'b1, 1'b1, 8);
        check("R8 down wrap to new limit", int'(count), 9);
        check("R4 A steps down", int'(dir_down), 1);
        check("R8 down wrap pulse", wraps, 4);

        // R5: phase B only
        set_mode(2'd2);
        move(1'b0, 1'b1, 8);
        check("R5 A ignored count", int'(count), 9);
        check("R5 A ignored dir", int'(dir_down), 1);
        move(1'b0, 1'b0, 8);
        check("R5 B steps up wrap", int'(count), 0);
        check("R5 B dir up", int'(dir_down), 0);

        // R11: invert phase A, same pin motion now steps down
        set_mode(2'd0);
        @(negedge clk); inv_a = 1'b1;
        repeat (8) @(negedge clk);
        set_mode(2'd3);
        move(1'b1, 1'b0, 8);
        check("R11 inverted direction", int'(dir_down), 1);
        check("R11 inverted count", int'(count), 9);
        set_mode(2'd0);
        @(negedge clk); inv_a = 1'b0;
        repeat (8) @(negedge clk);

        // R12: filter of 4 samples, strobe every second cycle
        @(negedge clk); flt_len = 4'd4;
        repeat (20) @(negedge clk);
        set_mode(2'd3);
        move(1'b1, 1'b1, 3);
        move(1'b1, 1'b0, 30);
        check("R12 glitch rejected", int'(count), 9);
        check("R12 glitch no err", errs, 1);
        move(1'b1, 1'b1, 30);
        check("R12 held level accepted", int'(count), 0);
        check("R12 direction up", int'(dir_down), 0);

        // R1: reset from a nonzero state
        move(1'b0, 1'b1, 30);
        check("R1 precondition", int'(count), 1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 count after reset", int'(count), 0);
        check("R1 dir after reset", int'(dir_down), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule